// File: doc/BRIEF.md
# Memory-Mapped GPIO with Edge Capture

This peripheral gives a host a bank of up to 32 general-purpose pins on a small word-addressed register bus. Software chooses the direction of each pin, writes the values driven on output pins, and reads back the levels seen on the pins. Each pin presents a drive value and a drive enable, so a pad ring can form a tristate buffer from them. Each pin input passes through a two-stage synchronizer before any logic uses it.

A single interrupt line reports activity to the host. The trigger kind is set by a parameter when the design is built: rising edge, falling edge, either edge, or level high. In the three edge kinds, a qualifying transition latches a sticky bit in a capture register. Software clears that bit by writing a one to it. The interrupt follows the captured bits that software has enabled. In level kind the interrupt follows the enabled pin levels directly.

Top module: `gpio_edge_cap`

## Requirements
- R1: While reset is asserted and after it is released, the output data, direction, mask and capture registers hold zero, `pin_oe` and `irq` are low, and `rd_data` reads zero.
- R2: The registers decode at byte offsets 0x0 (pin data), 0x4 (direction), 0x8 (interrupt enable) and 0xC (capture). Any other offset, including a misaligned one, reads zero and ignores writes.
- R3: Writing offset 0x0 sets `pin_out`. Direction bit n set to 1 drives `pin_oe[n]` high, which makes pin n an output. Reading offset 0x0 returns the pin input levels after the two-flop synchronizer. `pin_oe` changes only on a direction write.
- R4: Register bits at positions at or above NPINS read as zero and ignore writes.
- R5: Read data appears on `rd_data` in the cycle after the one in which `rd_en` is high. `rd_data` is zero after any cycle without a read.
- R6: TRIG_MODE selects the trigger: 0 rising, 1 falling, 2 either edge, 3 level high. In modes 0 to 2, a qualifying change of the synchronized input, compared with its value one clock earlier, sets the capture bit. A capture bit becomes set only through such an event.
- R7: Writing 1 to a capture bit clears it, and writing 0 leaves it unchanged. When a new event and a clearing write reach the same bit in the same cycle, the bit stays set.
- R8: In edge modes, `irq` is high exactly when some capture bit and its enable bit are both 1. A disabled pin keeps its capture bit set but does not raise `irq`.
- R9: In level mode, `irq` is high exactly when some synchronized input level and its enable bit are both 1, and the capture register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after the strobe |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Drive value per pin |
| pin_oe | output | NPINS | Drive enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check several rules on every clock. Read data must return to zero after a cycle with no read. Drive enables must hold still unless the direction register is written. No capture bit may become set without a detected event, and a detected event must leave its bit set even when a clearing write reaches it in the same cycle. The interrupt may not rise while every enable bit is zero. Other behaviour shows only in the bench's scenarios, run against four builds, one per trigger mode, and compared each cycle with a behavioural model. That covers which transitions each mode captures, the two-cycle synchronizer latency, the write-one-to-clear rules, upper-bit masking at NPINS=12, unmapped and misaligned offsets, and the interrupt of level mode following the live pins.

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap #(
  parameter int NPINS     = 32,
  parameter int TRIG_MODE = 0,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DIR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CAP  = ADDR_W'(12);
  localparam bit LEVEL_MODE = (TRIG_MODE == 3);

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] data_q, dir_q, mask_q, cap_q;
  logic [NPINS-1:0] ev, clr;
  logic [31:0]      rd_next;

  wire sel_data = (addr == OFF_DATA);
  wire sel_dir  = (addr == OFF_DIR);
  wire sel_mask = (addr == OFF_MASK);
  wire sel_cap  = (addr == OFF_CAP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  generate
    if (TRIG_MODE == 0) begin : g_rise
      assign ev = sync2 & ~prev;
    end else if (TRIG_MODE == 1) begin : g_fall
      assign ev = ~sync2 & prev;
    end else if (TRIG_MODE == 2) begin : g_both
      assign ev = sync2 ^ prev;
    end else begin : g_level
      assign ev = '0;
    end
  endgenerate

  assign clr = (wr_en && sel_cap) ? wr_data[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_en && sel_data) data_q <= wr_data[NPINS-1:0];
      if (wr_en && sel_dir)  dir_q  <= wr_data[NPINS-1:0];
      if (wr_en && sel_mask) mask_q <= wr_data[NPINS-1:0];
      cap_q <= (cap_q & ~clr) | ev;
    end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      if (sel_data)      rd_next[NPINS-1:0] = sync2;
      else if (sel_dir)  rd_next[NPINS-1:0] = dir_q;
      else if (sel_mask) rd_next[NPINS-1:0] = mask_q;
      else if (sel_cap)  rd_next[NPINS-1:0] = cap_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign irq     = LEVEL_MODE ? |(sync2 & mask_q) : |(cap_q & mask_q);

  // R5
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));

  // R3
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_dir) |=> $stable(pin_oe));

  // R6
  cap_set_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_q & ~$past(cap_q) & ~$past(ev)) == '0));

  // R7
  event_wins_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((cap_q & $past(ev)) == $past(ev)));

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

endmodule

// File: tb/gpio_edge_cap_bench.sv
module gpio_edge_cap_bench;
  localparam int NP = 12;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NP-1:0] pin_in = '0;

  logic [31:0]   rdq  [4];
  logic [NP-1:0] pout [4];
  logic [NP-1:0] poe  [4];
  logic          irqv [4];

  always #4 clk = ~clk;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    gpio_edge_cap #(.NPINS(NP), .TRIG_MODE(m), .ADDR_W(AW)) u_gpio_edge_cap (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rdq[m]), .pin_in(pin_in), .pin_out(pout[m]),
      .pin_oe(poe[m]), .irq(irqv[m]));
  end

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  logic [NP-1:0] h0, h1, h2, m_data, m_dir, m_mask;
  logic [NP-1:0] m_cap [4];
  logic [31:0]   m_rd  [4];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0;
      m_data = '0; m_dir = '0; m_mask = '0;
      for (int m = 0; m < 4; m++) begin m_cap[m] = '0; m_rd[m] = '0; end
    end else begin
      logic [NP-1:0] clr, ev;
      clr = (wr_en && addr == 5'h0C) ? wr_data[NP-1:0] : '0;
      for (int m = 0; m < 4; m++) begin
        m_rd[m] = '0;
        if (rd_en) begin
          if (addr == 5'h00)      m_rd[m] = {20'b0, h1};
          else if (addr == 5'h04) m_rd[m] = {20'b0, m_dir};
          else if (addr == 5'h08) m_rd[m] = {20'b0, m_mask};
          else if (addr == 5'h0C) m_rd[m] = {20'b0, m_cap[m]};
        end
        if (m == 0)      ev = h1 & ~h2;
        else if (m == 1) ev = ~h1 & h2;
        else if (m == 2) ev = h1 ^ h2;
        else             ev = '0;
        m_cap[m] = (m_cap[m] & ~clr) | ev;
      end
      if (wr_en && addr == 5'h00) m_data = wr_data[NP-1:0];
      if (wr_en && addr == 5'h04) m_dir  = wr_data[NP-1:0];
      if (wr_en && addr == 5'h08) m_mask = wr_data[NP-1:0];
      h2 = h1; h1 = h0; h0 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int m = 0; m < 4; m++) begin
        check("R3 pin_out", {20'b0, pout[m]}, {20'b0, m_data});
        check("R3 pin_oe", {20'b0, poe[m]}, {20'b0, m_dir});
        check("R5 rd_data", rdq[m], m_rd[m]);
        if (m == 3) check("R9 irq", {31'b0, irqv[m]}, {31'b0, |(h1 & m_mask)});
        else        check("R8 irq", {31'b0, irqv[m]}, {31'b0, |(m_cap[m] & m_mask)});
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    for (int m = 0; m < 4; m++) begin
      check("R1 reset oe", {20'b0, poe[m]}, 32'h0);
      check("R1 reset irq", {31'b0, irqv[m]}, 32'h0);
      check("R1 reset rd", rdq[m], 32'h0);
    end
    rst_n = 1'b1;
    idle(2);
    rd(5'h0C);
    for (int m = 0; m < 4; m++) check("R1 capture after reset", rdq[m], 32'h0);

    wr(5'h00, 32'h0000_0ABC);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04);
    check("R4 upper direction bits", rdq[0], 32'h0000_0FFF);
    check("R3 pin_out value", {20'b0, pout[0]}, 32'h0000_0ABC);
    wr(5'h04, 32'h0000_00F0);
    rd(5'h04);
    check("R2 direction offset", rdq[1], 32'h0000_00F0);

    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10);
    check("R2 unmapped reads zero", rdq[0], 32'h0);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h02);
    check("R2 misaligned reads zero", rdq[2], 32'h0);
    rd(5'h04);
    check("R2 unmapped write ignored", rdq[2], 32'h0000_00F0);

    pin_in = 12'h5A5;
    idle(3);
    rd(5'h00);
    check("R3 pin readback", rdq[0], 32'h0000_05A5);
    pin_in = '0;
    idle(4);
    wr(5'h0C, 32'hFFFF_FFFF);
    idle(1);
    rd(5'h0C);
    for (int m = 0; m < 4; m++) check("R7 clear all", rdq[m], 32'h0);

    wr(5'h08, 32'h0000_0FFF);
    pin_in = 12'h001;
    idle(3);
    rd(5'h0C);
    check("R6 rising sees rise", rdq[0], 32'h1);
    check("R6 falling ignores rise", rdq[1], 32'h0);
    check("R6 both sees rise", rdq[2], 32'h1);
    check("R9 level capture zero", rdq[3], 32'h0);
    check("R9 level irq high", {31'b0, irqv[3]}, 32'h1);
    check("R8 rising irq", {31'b0, irqv[0]}, 32'h1);
    check("R8 falling no irq", {31'b0, irqv[1]}, 32'h0);
    pin_in = '0;
    idle(3);
    rd(5'h0C);
    check("R6 falling sees fall", rdq[1], 32'h1);
    check("R6 rising keeps bit", rdq[0], 32'h1);
    check("R9 level irq low", {31'b0, irqv[3]}, 32'h0);

    wr(5'h0C, 32'h0);
    rd(5'h0C);
    check("R7 write zero keeps", rdq[2], 32'h1);
    wr(5'h0C, 32'h1);
    rd(5'h0C);
    for (int m = 0; m < 3; m++) check("R7 write one clears", rdq[m], 32'h0);

    pin_in = 12'h002;
    idle(3);
    pin_in = '0;
    idle(3);
    pin_in = 12'h002;
    idle(2);
    wr(5'h0C, 32'h2);
    idle(2);
    rd(5'h0C);
    check("R7 event beats clear rising", rdq[0], 32'h2);
    check("R7 clear without event falling", rdq[1], 32'h0);
    check("R7 event beats clear both", rdq[2], 32'h2);

    wr(5'h08, 32'h0);
    idle(1);
    check("R8 masked no irq", {31'b0, irqv[0]}, 32'h0);
    check("R9 masked level no irq", {31'b0, irqv[3]}, 32'h0);
    rd(5'h0C);
    check("R8 masked bit kept", rdq[0], 32'h2);
    wr(5'h08, 32'hFFFF_F002);
    idle(1);
    check("R8 unmasked irq", {31'b0, irqv[0]}, 32'h1);
    check("R9 unmasked level irq", {31'b0, irqv[3]}, 32'h1);
    rd(5'h08);
    check("R4 upper mask bits", rdq[0], 32'h2);
    idle(2);
    check("R5 idle rd_data", rdq[0], 32'h0);

    idle(2);
    finish_run();
  end
endmodule